// File: doc/BRIEF.md
# Register-File Packet Input Dispatcher

This block loads a packet into a processor without any load instructions in software. Header words and flow-state words arrive on two 32-bit word streams. The block writes them straight into one bank of the processor register file through a dedicated write port. The register file holds two packet banks of 32 registers each, at addresses 0–31 and 32–63. A third set at addresses 64–95 stays reserved for program variables. Packets go to the banks in strict alternation, starting with bank 0, so software always knows which bank holds its next packet.

While waiting, the software spins in a loop that jumps through register 4 of the program set. Once every word of a packet has been written, the block looks up a handler entry address for the packet type in a small dispatch table. It then writes that address into register 4. The spin loop now jumps to the handler, which starts processing.

The processor reports an Idle level: high while it spins, low while it processes. The block raises a packet-available flag along with each dispatch write and clears it once Idle falls. A new dispatch write is made only while the processor spins and the previous dispatch has been taken up. Each dispatch therefore lands only after the processor has finished the other bank. The dispatch table is written over a small configuration port, which is open only between packets.

Top module: `rf_pkt_loader`

## Requirements
- R1: After reset, rf_we and pkt_avail are 0, st_ready is 0, and fld_ready is 1.
- R2: Field words are written in arrival order to offsets 0, 1, 2, … of the current bank. State words continue at the offset after the last field word. The register address is bank×32 + offset. Packets of 10, 20 and 30 field words are loaded completely. Each accepted word appears on the write port in the cycle after its acceptance edge.
- R3: Words that fall beyond offset 31 of a bank are still accepted (ready stays high), but they are not written.
- R4: After the last data write of a packet, exactly one dispatch write follows, to address 68 (register 4 of the program set at 64–95). pkt_avail is high from that write until the edge at which Idle is first seen low, and is 0 after that edge.
- R5: The dispatch write is issued only at a clock edge where cpu_idle is 1 and pkt_avail is 0. Otherwise it is held back.
- R6: The handler address is the table entry for the packet type if that entry is enabled. Otherwise it is the address in entry 0, the default handler. The type is taken with the first field word.
- R7: Successive packets use bank 0, bank 1, bank 0, … in turn.
- R8: From the edge that accepts the last field word until the dispatch write, fld_ready is 0 and no new packet word is written. st_ready is 1 only while state words are expected. The state stream carries at least one word, ended by st_last.
- R9: A configuration write made while a packet is in progress (from its first accepted field word until its dispatch write) leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fld_valid | input | 1 | Field word valid |
| fld_ready | output | 1 | Field word accepted at the next edge when valid |
| fld_data | input | 32 | Field word |
| fld_last | input | 1 | Last field word of the packet |
| fld_type | input | 3 | Packet type, sampled with the first field word |
| st_valid | input | 1 | Flow-state word valid |
| st_ready | output | 1 | Flow-state word accepted at the next edge when valid |
| st_data | input | 32 | Flow-state word |
| st_last | input | 1 | Last flow-state word |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | 7 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| cpu_idle | input | 1 | Processor Idle level |
| pkt_avail | output | 1 | Dispatched packet not yet taken up |
| cfg_we | input | 1 | Dispatch table write strobe |
| cfg_sel | input | 3 | Table entry (packet type) to write |
| cfg_en | input | 1 | Entry enable written with the address |
| cfg_pc | input | 32 | Handler entry address |

## Verification
The bench builds the block with its default parameters: 32 registers per bank, two banks, dispatch register 4 and a 3-bit type. With these values the 30-word packet with four state words runs past offset 31, and the third packet wraps back to bank 0. Dispatch is held back twice, once by Idle being low and once by an unacknowledged earlier dispatch. An unconfigured type falls back to entry 0. A table write arrives in the middle of a packet.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_FIELDS,
        LD_STATE,
        LD_DISPATCH
    } ld_state_e;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] pc;
    } disp_ent_t;

    function automatic int unsigned reg_index(input int unsigned bank,
                                              input int unsigned off,
                                              input int unsigned regs);
        return bank * regs + off;
    endfunction

endpackage

// File: rtl/rfl_dispatch_tbl.sv
module rfl_dispatch_tbl #(
    parameter int TYPE_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_open,
    input  logic                      cfg_we,
    input  logic [TYPE_W-1:0]         cfg_sel,
    input  logic                      cfg_en,
    input  logic [rfl_pkg::WORD_W-1:0] cfg_pc,
    input  logic [TYPE_W-1:0]         lk_type,
    output logic [rfl_pkg::WORD_W-1:0] lk_pc
);
    localparam int NUM_TYPES = 1 << TYPE_W;

    rfl_pkg::disp_ent_t [NUM_TYPES-1:0] ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (cfg_we && cfg_open) begin
            ent[cfg_sel] <= '{en: cfg_en, pc: cfg_pc};
        end
    end

    always_comb begin
        if (ent[lk_type].en) lk_pc = ent[lk_type].pc;
        else                 lk_pc = ent[0].pc;
    end

    // R9: a write outside the open window leaves every entry untouched
    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_open) |=> $stable(ent));

endmodule

// File: rtl/rfl_handoff.sv
module rfl_handoff (
    input  logic clk,
    input  logic rst,
    input  logic cpu_idle,
    input  logic disp_fire,
    output logic pend,
    output logic may_dispatch
);
    logic idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b1;
            pend   <= 1'b0;
        end else begin
            idle_q <= cpu_idle;
            if (disp_fire)                pend <= 1'b1;
            else if (idle_q && !cpu_idle) pend <= 1'b0;
        end
    end

    assign may_dispatch = cpu_idle && !pend;

    // R4: a falling Idle takes up the outstanding dispatch
    p_pend_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (pend && idle_q && !cpu_idle) |=> !pend);

endmodule

// File: rtl/rfl_fill.sv
module rfl_fill #(
    parameter int BANK_REGS = 32,
    parameter int NUM_BANKS = 2,
    parameter int TYPE_W    = 3,
    parameter int DISP_REG  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fld_valid,
    output logic                       fld_ready,
    input  logic [rfl_pkg::WORD_W-1:0] fld_data,
    input  logic                       fld_last,
    input  logic [TYPE_W-1:0]          fld_type,
    input  logic                       st_valid,
    output logic                       st_ready,
    input  logic [rfl_pkg::WORD_W-1:0] st_data,
    input  logic                       st_last,
    input  logic                       may_dispatch,
    input  logic [rfl_pkg::WORD_W-1:0] handler_pc,
    output logic [TYPE_W-1:0]          pkt_type,
    output logic                       loader_idle,
    output logic                       disp_fire,
    output logic                       rf_we,
    output logic [$clog2((NUM_BANKS+1)*BANK_REGS)-1:0] rf_addr,
    output logic [rfl_pkg::WORD_W-1:0] rf_wdata
);
    import rfl_pkg::*;

    localparam int RF_AW = $clog2((NUM_BANKS+1)*BANK_REGS);
    localparam int PTR_W = $clog2(BANK_REGS) + 1;
    localparam int BW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [RF_AW-1:0] DISP_ADDR = RF_AW'(NUM_BANKS*BANK_REGS + DISP_REG);
    localparam logic [PTR_W-1:0] PTR_END   = PTR_W'(BANK_REGS);

    ld_state_e         st_q;
    logic [PTR_W-1:0]  ptr;
    logic [BW-1:0]     bank_q;
    logic              fld_acc, st_acc;

    assign fld_ready   = (st_q == LD_IDLE) || (st_q == LD_FIELDS);
    assign st_ready    = (st_q == LD_STATE);
    assign fld_acc     = fld_valid && fld_ready;
    assign st_acc      = st_valid && st_ready;
    assign loader_idle = (st_q == LD_IDLE);
    assign disp_fire   = (st_q == LD_DISPATCH) && may_dispatch;

    function automatic logic [RF_AW-1:0] word_addr(input logic [BW-1:0] b,
                                                   input logic [PTR_W-1:0] off);
        return RF_AW'(reg_index(int'(b), int'(off), BANK_REGS));
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= LD_IDLE;
            ptr      <= '0;
            bank_q   <= '0;
            pkt_type <= '0;
            rf_we    <= 1'b0;
            rf_addr  <= '0;
            rf_wdata <= '0;
        end else begin
            rf_we <= 1'b0;
            unique case (st_q)
                LD_IDLE: if (fld_acc) begin
                    pkt_type <= fld_type;
                    rf_we    <= 1'b1;
                    rf_addr  <= word_addr(bank_q, '0);
                    rf_wdata <= fld_data;
                    ptr      <= PTR_W'(1);
                    st_q     <= fld_last ? LD_STATE : LD_FIELDS;
                end
                LD_FIELDS: if (fld_acc) begin
                    if (ptr != PTR_END) begin
                        rf_we    <= 1'b1;
                        rf_addr  <= word_addr(bank_q, ptr);
                        rf_wdata <= fld_data;
                        ptr      <= ptr + PTR_W'(1);
                    end
                    if (fld_last) st_q <= LD_STATE;
                end
                LD_STATE: if (st_acc) begin
                    if (ptr != PTR_END) begin
                        rf_we    <= 1'b1;
                        rf_addr  <= word_addr(bank_q, ptr);
                        rf_wdata <= st_data;
                        ptr      <= ptr + PTR_W'(1);
                    end
                    if (st_last) st_q <= LD_DISPATCH;
                end
                LD_DISPATCH: if (may_dispatch) begin
                    rf_we    <= 1'b1;
                    rf_addr  <= DISP_ADDR;
                    rf_wdata <= handler_pc;
                    bank_q   <= (bank_q == BW'(NUM_BANKS-1)) ? '0 : bank_q + BW'(1);
                    st_q     <= LD_IDLE;
                end
                default: st_q <= LD_IDLE;
            endcase
        end
    end

    // R3: a word arriving with the bank already full produces no write
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        ((fld_acc && st_q == LD_FIELDS) || st_acc) && ptr == PTR_END |=> !rf_we);

    // R8: the two streams are never open at once
    p_ready_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(fld_ready && st_ready));

endmodule

// File: rtl/rf_pkt_loader.sv
module rf_pkt_loader #(
    parameter int BANK_REGS = 32,
    parameter int NUM_BANKS = 2,
    parameter int TYPE_W    = 3,
    parameter int DISP_REG  = 4,
    parameter int RF_AW     = $clog2((NUM_BANKS+1)*BANK_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fld_valid,
    output logic              fld_ready,
    input  logic [31:0]       fld_data,
    input  logic              fld_last,
    input  logic [TYPE_W-1:0] fld_type,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [31:0]       st_data,
    input  logic              st_last,
    output logic              rf_we,
    output logic [RF_AW-1:0]  rf_addr,
    output logic [31:0]       rf_wdata,
    input  logic              cpu_idle,
    output logic              pkt_avail,
    input  logic              cfg_we,
    input  logic [TYPE_W-1:0] cfg_sel,
    input  logic              cfg_en,
    input  logic [31:0]       cfg_pc
);
    localparam logic [RF_AW-1:0] DISP_ADDR = RF_AW'(NUM_BANKS*BANK_REGS + DISP_REG);

    logic              may_dispatch, disp_fire, loader_idle;
    logic [TYPE_W-1:0] pkt_type;
    logic [31:0]       handler_pc;

    rfl_dispatch_tbl #(.TYPE_W(TYPE_W)) u_tbl (
        .clk(clk), .rst(rst), .cfg_open(loader_idle), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_pc(cfg_pc),
        .lk_type(pkt_type), .lk_pc(handler_pc)
    );

    rfl_handoff u_handoff (
        .clk(clk), .rst(rst), .cpu_idle(cpu_idle), .disp_fire(disp_fire),
        .pend(pkt_avail), .may_dispatch(may_dispatch)
    );

    rfl_fill #(
        .BANK_REGS(BANK_REGS), .NUM_BANKS(NUM_BANKS),
        .TYPE_W(TYPE_W), .DISP_REG(DISP_REG)
    ) u_fill (
        .clk(clk), .rst(rst),
        .fld_valid(fld_valid), .fld_ready(fld_ready), .fld_data(fld_data),
        .fld_last(fld_last), .fld_type(fld_type),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_last(st_last),
        .may_dispatch(may_dispatch), .handler_pc(handler_pc),
        .pkt_type(pkt_type), .loader_idle(loader_idle), .disp_fire(disp_fire),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata)
    );

    // R5: dispatch only onto a spinning processor with nothing outstanding
    p_disp_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (rf_we && rf_addr == DISP_ADDR) |-> ($past(cpu_idle) && !$past(pkt_avail)));

    // R4: the dispatch write raises the packet-available flag
    p_avail_on_disp_r4: assert property (@(posedge clk) disable iff (rst)
        (rf_we && rf_addr == DISP_ADDR) |-> pkt_avail);

    // R8: no field word is taken between the last field word and dispatch
    p_hold_fields_r8: assert property (@(posedge clk) disable iff (rst)
        st_ready |-> !fld_ready);

endmodule

// File: tb/rf_pkt_loader_test.sv
module rf_pkt_loader_test;
    logic        clk = 0, rst = 1;
    logic        fld_valid = 0, fld_last = 0, st_valid = 0, st_last = 0;
    logic [31:0] fld_data = 0, st_data = 0, cfg_pc = 0;
    logic [2:0]  fld_type = 0, cfg_sel = 0;
    logic        cpu_idle = 1, cfg_we = 0, cfg_en = 0;
    logic        fld_ready, st_ready, rf_we, pkt_avail;
    logic [6:0]  rf_addr;
    logic [31:0] rf_wdata;

    rf_pkt_loader uut (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int exp_addr[$];
    int unsigned exp_data[$];
    int unsigned tbl_pc[8];
    bit tbl_en[8];
    int bank = 0;
    logic idle_e = 1, pav_e = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        idle_e = cpu_idle;
        pav_e  = pkt_avail;
    end

    // write-port reference: every write must match the next expected one
    always @(negedge clk) begin
        if (!rst && rf_we) begin
            if (exp_addr.size() == 0) begin
                chk(0, "R8 unexpected write addr", rf_addr, 0);
            end else begin
                int a;
                int unsigned d;
                a = exp_addr.pop_front();
                d = exp_data.pop_front();
                chk(rf_addr == 7'(a), "R2/R4/R7 address", rf_addr, a);
                chk(rf_wdata == d, "R2/R6 data", rf_wdata, d);
                if (a == 68)
                    chk(idle_e && !pav_e, "R5 dispatch gating", {idle_e, pav_e}, 2'b10);
            end
        end
    end

    function automatic int unsigned handler(input int t);
        return tbl_en[t] ? tbl_pc[t] : tbl_pc[0];
    endfunction

    task automatic cfg(input int t, input bit en, input int unsigned pc, input bit takes);
        cfg_we = 1; cfg_sel = 3'(t); cfg_en = en; cfg_pc = pc;
        @(negedge clk);
        cfg_we = 0;
        if (takes) begin tbl_en[t] = en; tbl_pc[t] = pc; end
    endtask

    task automatic send_pkt(input int t, input int nf, input int ns, input logic [15:0] seed);
        int off = 0;
        for (int i = 0; i < nf; i++) begin
            fld_valid = 1; fld_type = 3'(t); fld_last = (i == nf-1);
            fld_data = {seed, 16'(i)};
            while (!fld_ready) @(negedge clk);
            if (off < 32) begin exp_addr.push_back(bank*32 + off); exp_data.push_back(fld_data); end
            off++;
            @(negedge clk);
        end
        fld_valid = 0; fld_last = 0;
        for (int i = 0; i < ns; i++) begin
            st_valid = 1; st_last = (i == ns-1);
            st_data = {~seed, 16'(i)};
            while (!st_ready) @(negedge clk);
            if (off < 32) begin exp_addr.push_back(bank*32 + off); exp_data.push_back(st_data); end
            off++;
            @(negedge clk);
        end
        st_valid = 0; st_last = 0;
        exp_addr.push_back(68); exp_data.push_back(handler(t));
        bank ^= 1;
    endtask

    task automatic drain;
        while (exp_addr.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(rf_we == 0,     "R1 rf_we",     rf_we, 0);
        chk(pkt_avail == 0, "R1 pkt_avail", pkt_avail, 0);
        chk(fld_ready == 1, "R1 fld_ready", fld_ready, 1);
        chk(st_ready == 0,  "R1 st_ready",  st_ready, 0);

        cfg(0, 1, 32'h100, 1);
        cfg(1, 1, 32'h200, 1);
        cfg(2, 1, 32'h300, 1);

        // packet A: 10 words into bank 0, enabled type (R2, R6, R7)
        send_pkt(1, 10, 2, 16'hA000);
        drain();
        @(negedge clk);
        chk(pkt_avail == 1, "R4 avail after dispatch", pkt_avail, 1);
        cpu_idle = 0;
        @(negedge clk);
        chk(pkt_avail == 0, "R4 avail cleared by idle fall", pkt_avail, 0);

        // packet B: 20 words into bank 1, unconfigured type -> entry 0 (R6)
        send_pkt(5, 20, 2, 16'hB000);
        repeat (5) @(negedge clk);
        chk(exp_addr.size() == 1, "R5 held while idle low", exp_addr.size(), 1);
        chk(fld_ready == 0, "R8 fld_ready during wait", fld_ready, 0);
        chk(st_ready == 0,  "R8 st_ready during wait",  st_ready, 0);
        cfg(2, 1, 32'h999, 0);           // R9: must be ignored
        fld_valid = 1; fld_data = 32'hDEAD; fld_type = 3'd2;
        repeat (3) @(negedge clk);       // R8: offered word must not be written
        fld_valid = 0;
        cpu_idle = 1;
        drain();

        // packet C: 30 fields + 4 state, overflow past 31 (R3); back to bank 0 (R7)
        send_pkt(2, 30, 4, 16'hC000);
        repeat (4) @(negedge clk);
        chk(exp_addr.size() == 1, "R5 held while dispatch outstanding", exp_addr.size(), 1);
        cpu_idle = 0;
        repeat (3) @(negedge clk);
        chk(exp_addr.size() == 1, "R5 held while processing", exp_addr.size(), 1);
        cpu_idle = 1;
        drain();
        @(negedge clk);
        chk(pkt_avail == 1, "R4 avail for packet C", pkt_avail, 1);
        cpu_idle = 0;
        @(negedge clk);
        cpu_idle = 1;

        // packet D: type 5 now configured between packets (R6, R9)
        cfg(5, 1, 32'h500, 1);
        send_pkt(5, 10, 1, 16'hD000);
        drain();
        repeat (2) @(negedge clk);
        chk(exp_addr.size() == 0, "R2 all writes seen", exp_addr.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule